// File: doc/BRIEF.md
# FSK Tag Demodulator

This block recovers 44-bit identifiers from a low-frequency tag that answers with frequency-shift keying. The tag switches its load at either one eighth or one tenth of the reader carrier. The block takes a stream of 8-bit envelope samples, at most one per clock, qualified by a valid strobe. Each sample is sliced to one bit. The number of samples between rising edges sorts every carrier cycle into a short (fc/8) or long (fc/10) class.

Runs of cycles of the same class are turned into half-bit counts. The half-bits pass through a six-place window. A start-of-frame marker opens a frame, and Manchester pairs after the marker are shifted into the identifier. When the next marker arrives, the identifier collected so far is reported. In single-shot mode the first identifier reported is kept on the output, and later ones are blocked until software clears the hold.

Top module: `fsk_tag_demod`

## Requirements
- R1: A sample is sliced to 1 when its value is 127 or more, and to 0 when it is 126 or less.
- R2: A rising edge is a slice of 1 that follows a slice of 0, with distance counted in valid samples only, so idle clocks have no effect. The first rising edge after reset only starts the timing. The distance from the previous rising edge gives a cycle symbol: 1 when the distance is 8 or less, and 0 when it is 9 or more.
- R3: A run of like cycle symbols is converted when a symbol of the other value arrives. A run of n symbols 1 gives a half-bit count of (n+1)/6, and a run of n symbols 0 gives (n+1)/5, both with integer division. The half-bit value equals the run's symbol. Six fc/8 cycles therefore make one half-bit 1, and five fc/10 cycles make one half-bit 0.
- R4: A count of 0 or 1 emits one half-bit. A count of 2, 3 or 4 emits that many half-bits. A count of 5 or more emits nothing, so the run vanishes from the half-bit stream.
- R5: The half-bits 1,1,1,0,0,0, in arrival order, form a frame marker. A marker opens a frame with an empty identifier, and its six half-bits are not decoded as data.
- R6: Inside a frame, half-bits are taken in pairs starting right after the marker. The pair 1,0 shifts a 0 into the low end of the 44-bit identifier, and the pair 0,1 shifts a 1. A pair 1,1 or 0,0 abandons the frame, so the next marker reports nothing.
- R7: A marker that closes an open frame with a nonzero identifier raises id_valid for one clock, with the identifier on id_value, most significant bit first as received. A closing marker with an all-zero identifier reports nothing. Every closing marker also opens the next frame.
- R8: With one_shot high, a report sets id_held. While id_held is high, id_valid stays low and id_value stays unchanged. A hold_clear pulse drops id_held, and the next frame is reported again.
- R9: After reset, id_valid, id_held and id_value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| one_shot | input | 1 | Keep the first reported identifier and block later reports |
| hold_clear | input | 1 | Releases a held identifier |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Envelope sample |
| id_valid | output | 1 | One-clock pulse for a new identifier |
| id_value | output | 44 | Last reported identifier |
| id_held | output | 1 | An identifier is held in single-shot mode |

## Verification
The bench builds the block with its default parameters: 44-bit identifier, 8-bit samples, threshold 127, short limit 8, and divisors 6 and 5. These values match the field format, so whole frames of real length can be replayed. The 8-bit period and run counters never saturate on the patterns used. The bench can therefore reach the exact classification boundary (periods 8 and 9), the threshold boundary (126 against 127), runs of four and five half-bits, back-to-back frames that share a marker, and the hold in single-shot mode.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

  // Largest number of half-bits one run may emit.
  localparam int unsigned BURST_MAX = 4;

  // Half-bit count for a run of run_len cycles of symbol sym.
  function automatic int unsigned halfbit_count(input logic sym,
                                                input int unsigned run_len,
                                                input int unsigned div_short,
                                                input int unsigned div_long);
    return sym ? (run_len + 1) / div_short : (run_len + 1) / div_long;
  endfunction

  // Number of half-bits actually emitted for a count.
  function automatic int unsigned copies_for(input int unsigned cnt);
    if (cnt <= 1) return 1;
    if (cnt <= BURST_MAX) return cnt;
    return 0;
  endfunction

endpackage

// File: rtl/fsk_cycle_classifier.sv
module fsk_cycle_classifier #(
  parameter int SMP_W     = 8,
  parameter int THRESH    = 127,
  parameter int SHORT_MAX = 8,
  parameter int PER_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             cyc_valid,
  output logic             cyc_sym
);
  localparam logic [SMP_W-1:0] THR       = THRESH[SMP_W-1:0];
  localparam logic [PER_W:0]   SHORT_LIM = SHORT_MAX[PER_W:0];
  localparam logic [PER_W-1:0] PER_MAX   = '1;

  logic             prev_q, primed_q;
  logic [PER_W-1:0] per_q;
  logic             slice_bit, rise_evt;
  logic [PER_W:0]   period;

  assign slice_bit = (smp_data >= THR);
  assign rise_evt  = smp_valid && slice_bit && !prev_q;
  assign period    = {1'b0, per_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b1;
      primed_q  <= 1'b0;
      per_q     <= '0;
      cyc_valid <= 1'b0;
      cyc_sym   <= 1'b0;
    end else begin
      cyc_valid <= 1'b0;
      if (smp_valid) begin
        prev_q <= slice_bit;
        if (rise_evt) begin
          per_q    <= '0;
          primed_q <= 1'b1;
          if (primed_q) begin
            cyc_valid <= 1'b1;
            cyc_sym   <= (period <= SHORT_LIM);
          end
        end else if (per_q != PER_MAX) begin
          per_q <= per_q + 1'b1;
        end
      end
    end
  end

  // Two rising edges are at least two samples apart.
  assert_cycle_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

endmodule

// File: rtl/fsk_run_packer.sv
module fsk_run_packer import fsk_tag_pkg::*; #(
  parameter int RUN_W     = 8,
  parameter int DIV_SHORT = 6,
  parameter int DIV_LONG  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_valid,
  input  logic       cyc_sym,
  output logic       hb_valid,
  output logic       hb_val,
  output logic [2:0] hb_cnt
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic             have_q, cur_q;
  logic [RUN_W-1:0] len_q;
  int unsigned      hb_num, hb_copies;
  logic             run_end;

  assign run_end = cyc_valid && have_q && (cyc_sym != cur_q);

  always_comb begin
    hb_num    = halfbit_count(cur_q, 32'(len_q), DIV_SHORT, DIV_LONG);
    hb_copies = copies_for(hb_num);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      cur_q    <= 1'b0;
      len_q    <= '0;
      hb_valid <= 1'b0;
      hb_val   <= 1'b0;
      hb_cnt   <= '0;
    end else begin
      hb_valid <= 1'b0;
      if (cyc_valid) begin
        if (!have_q) begin
          have_q <= 1'b1;
          cur_q  <= cyc_sym;
          len_q  <= RUN_ONE;
        end else if (!run_end) begin
          if (len_q != RUN_MAX) len_q <= len_q + 1'b1;
        end else begin
          if (hb_copies != 0) begin
            hb_valid <= 1'b1;
            hb_val   <= cur_q;
            hb_cnt   <= 3'(hb_copies);
          end
          cur_q <= cyc_sym;
          len_q <= RUN_ONE;
        end
      end
    end
  end

  assert_copies_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hb_valid |-> (hb_cnt >= 3'd1 && hb_cnt <= 3'd4));

  assert_emit_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hb_valid |=> !hb_valid);

endmodule

// File: rtl/fsk_frame_decoder.sv
module fsk_frame_decoder import fsk_tag_pkg::*; #(
  parameter int ID_W = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_valid,
  input  logic            hb_val,
  input  logic [2:0]      hb_cnt,
  output logic            rep,
  output logic [ID_W-1:0] rep_val
);
  localparam logic [5:0] MARK = 6'b111000;
  localparam logic [2:0] FULL = 3'd6;

  typedef struct packed {
    logic [ID_W-1:0] acc;
    logic [5:0]      win;
    logic [2:0]      fill;
    logic            found;
    logic            phase;
    logic            first;
  } frm_t;

  frm_t            st_q, s;
  logic            rep_nx, pop_bit;
  logic [ID_W-1:0] rep_val_nx;

  always_comb begin
    s          = st_q;
    rep_nx     = 1'b0;
    rep_val_nx = '0;
    pop_bit    = 1'b0;
    for (int i = 0; i < int'(BURST_MAX); i++) begin
      if (hb_valid && i < int'(hb_cnt)) begin
        // oldest half-bit leaves the window and is decoded
        if (s.fill == FULL) begin
          pop_bit = s.win[5];
          if (s.found) begin
            if (!s.phase) begin
              s.first = pop_bit;
              s.phase = 1'b1;
            end else begin
              s.phase = 1'b0;
              if (s.first != pop_bit) begin
                s.acc = {s.acc[ID_W-2:0], pop_bit};
              end else begin
                s.found = 1'b0;
                s.acc   = '0;
              end
            end
          end
        end
        s.win = {s.win[4:0], hb_val};
        if (s.fill != FULL) s.fill = s.fill + 3'd1;
        if (s.fill == FULL && s.win == MARK) begin
          if (s.found && s.acc != '0) begin
            rep_nx     = 1'b1;
            rep_val_nx = s.acc;
          end
          s.found = 1'b1;
          s.acc   = '0;
          s.phase = 1'b0;
          s.fill  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      rep     <= 1'b0;
      rep_val <= '0;
    end else begin
      st_q <= s;
      rep  <= rep_nx;
      if (rep_nx) rep_val <= rep_val_nx;
    end
  end

  assert_report_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rep |=> !rep);

endmodule

// File: rtl/fsk_tag_demod.sv
module fsk_tag_demod #(
  parameter int SMP_W     = 8,
  parameter int THRESH    = 127,
  parameter int SHORT_MAX = 8,
  parameter int DIV_SHORT = 6,
  parameter int DIV_LONG  = 5,
  parameter int PER_W     = 8,
  parameter int RUN_W     = 8,
  parameter int ID_W      = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            one_shot,
  input  logic            hold_clear,
  input  logic            smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic            id_valid,
  output logic [ID_W-1:0] id_value,
  output logic            id_held
);
  logic            cyc_valid, cyc_sym;
  logic            hb_valid, hb_val;
  logic [2:0]      hb_cnt;
  logic            frm_rep;
  logic [ID_W-1:0] frm_val;

  fsk_cycle_classifier #(.SMP_W(SMP_W), .THRESH(THRESH), .SHORT_MAX(SHORT_MAX), .PER_W(PER_W))
    u_classify (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
                .cyc_valid(cyc_valid), .cyc_sym(cyc_sym));

  fsk_run_packer #(.RUN_W(RUN_W), .DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG))
    u_pack (.clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_sym(cyc_sym),
            .hb_valid(hb_valid), .hb_val(hb_val), .hb_cnt(hb_cnt));

  fsk_frame_decoder #(.ID_W(ID_W))
    u_frame (.clk(clk), .rst_n(rst_n), .hb_valid(hb_valid), .hb_val(hb_val), .hb_cnt(hb_cnt),
             .rep(frm_rep), .rep_val(frm_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_value <= '0;
      id_held  <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      if (hold_clear) id_held <= 1'b0;
      if (frm_rep && !id_held) begin
        id_valid <= 1'b1;
        id_value <= frm_val;
        if (one_shot) id_held <= 1'b1;
      end
    end
  end

  assert_id_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (id_value != '0));

  assert_held_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_held && !hold_clear) |=> (!id_valid && $stable(id_value)));

endmodule

// File: tb/test_fsk_tag_demod.sv
module test_fsk_tag_demod;
  localparam int ID_W = 44;
  localparam logic [ID_W-1:0] ID_A = 44'hA5C_3F00_1234;
  localparam logic [ID_W-1:0] ID_B = 44'h1E2_7700_0C5B;
  localparam logic [ID_W-1:0] ID_C = 44'h803_0F0F_99A1;

  logic clk = 1'b0, rst_n = 1'b0, one_shot = 1'b0, hold_clear = 1'b0;
  logic smp_valid = 1'b0;
  logic [7:0] smp_data = 8'd0;
  logic id_valid, id_held;
  logic [ID_W-1:0] id_value;

  always #10 clk = ~clk;

  fsk_tag_demod i_fsk_tag_demod (
    .clk(clk), .rst_n(rst_n), .one_shot(one_shot), .hold_clear(hold_clear),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .id_valid(id_valid), .id_value(id_value), .id_held(id_held));

  int n_chk = 0, n_bad = 0, n_rep = 0, gap_cnt = 0;
  bit gap_mode = 0;
  int p_short = 8, p_long = 10;
  logic [7:0] lvl_hi = 8'd200, lvl_lo = 8'd20;
  logic [ID_W-1:0] rep_log [4];
  bit hb_q[$];

  always @(negedge clk) begin
    if (rst_n && id_valid) begin
      if (n_rep < 4) rep_log[n_rep] = id_value;
      n_rep++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; one_shot = 1'b0; hold_clear = 1'b0; smp_valid = 1'b0;
    gap_mode = 0; gap_cnt = 0; p_short = 8; p_long = 10;
    lvl_hi = 8'd200; lvl_lo = 8'd20; n_rep = 0;
    hb_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put_hb(input bit b, input int n);
    for (int k = 0; k < n; k++) hb_q.push_back(b);
  endtask

  task automatic put_marker();
    put_hb(1, 3); put_hb(0, 3);
  endtask

  task automatic put_id(input logic [ID_W-1:0] id);
    for (int k = ID_W - 1; k >= 0; k--) begin
      if (id[k]) begin put_hb(0, 1); put_hb(1, 1); end
      else begin put_hb(1, 1); put_hb(0, 1); end
    end
  endtask

  task automatic drive_sample(input logic [7:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = v;
    if (gap_mode) begin
      repeat (gap_cnt % 3) begin @(negedge clk); smp_valid = 1'b0; end
      gap_cnt++;
    end
  endtask

  task automatic send_cycle(input int p);
    drive_sample(lvl_hi); drive_sample(lvl_hi);
    for (int k = 2; k < p; k++) drive_sample(lvl_lo);
  endtask

  task automatic play();
    for (int k = 0; k < 3; k++) drive_sample(lvl_lo);
    foreach (hb_q[k]) begin
      if (hb_q[k]) repeat (6) send_cycle(p_short);
      else repeat (5) send_cycle(p_long);
    end
    @(negedge clk); smp_valid = 1'b0;
    repeat (12) @(negedge clk);
    hb_q.delete();
  endtask

  task automatic single_frame(input logic [ID_W-1:0] id);
    put_marker(); put_id(id); put_marker(); put_hb(1, 1);
  endtask

  task automatic t_reset();
    do_reset();
    check(id_valid == 1'b0, "R9", "id_valid after reset", 64'(id_valid), 0);
    check(id_held == 1'b0, "R9", "id_held after reset", 64'(id_held), 0);
    check(id_value == '0, "R9", "id_value after reset", 64'(id_value), 0);
  endtask

  task automatic t_basic();
    do_reset(); single_frame(ID_A); play();
    check(n_rep == 1, "R7", "report count basic", 64'(n_rep), 1);
    check(rep_log[0] == ID_A, "R6", "decoded id basic", 64'(rep_log[0]), 64'(ID_A));
  endtask

  task automatic t_threshold();
    do_reset(); lvl_hi = 8'd127; lvl_lo = 8'd126; single_frame(ID_B); play();
    check(n_rep == 1 && rep_log[0] == ID_B, "R1", "127 slices high, 126 low",
          64'(rep_log[0]), 64'(ID_B));
    do_reset(); lvl_hi = 8'd126; lvl_lo = 8'd20; single_frame(ID_B); play();
    check(n_rep == 0, "R1", "126 never slices high", 64'(n_rep), 0);
  endtask

  task automatic t_periods();
    do_reset(); p_short = 8; p_long = 9; single_frame(ID_C); play();
    check(n_rep == 1 && rep_log[0] == ID_C, "R2", "period 8 short, 9 long",
          64'(rep_log[0]), 64'(ID_C));
    do_reset(); p_short = 7; p_long = 11; single_frame(ID_A); play();
    check(n_rep == 1 && rep_log[0] == ID_A, "R2", "periods 7 and 11 tolerated",
          64'(rep_log[0]), 64'(ID_A));
  endtask

  task automatic t_gaps();
    do_reset(); gap_mode = 1; single_frame(ID_B); play();
    check(n_rep == 1 && rep_log[0] == ID_B, "R2", "idle clocks between samples",
          64'(rep_log[0]), 64'(ID_B));
  endtask

  task automatic t_long_runs();
    // ID_A starts with bit 1 (pair 0,1)
    do_reset(); put_marker(); put_hb(1, 5); put_id(ID_A); put_marker(); put_hb(1, 1); play();
    check(n_rep == 1 && rep_log[0] == ID_A, "R4", "run of five half-bits dropped",
          64'(rep_log[0]), 64'(ID_A));
    do_reset(); put_marker(); put_hb(1, 4); put_id(ID_A); put_marker(); put_hb(1, 1); play();
    check(n_rep == 0, "R6", "run of four emitted, bad pair abandons frame", 64'(n_rep), 0);
    check(id_value == '0, "R3", "no value after abandoned frame", 64'(id_value), 0);
  endtask

  task automatic t_zero_id();
    do_reset(); single_frame('0); play();
    check(n_rep == 0, "R7", "all-zero identifier not reported", 64'(n_rep), 0);
  endtask

  task automatic t_chain();
    do_reset();
    put_marker(); put_id(ID_A); put_marker(); put_id(ID_B); put_marker(); put_hb(1, 1);
    play();
    check(n_rep == 2, "R5", "shared marker opens next frame", 64'(n_rep), 2);
    check(rep_log[0] == ID_A, "R7", "first of chain", 64'(rep_log[0]), 64'(ID_A));
    check(rep_log[1] == ID_B, "R7", "second of chain", 64'(rep_log[1]), 64'(ID_B));
  endtask

  task automatic t_one_shot();
    do_reset(); one_shot = 1'b1;
    put_marker(); put_id(ID_A); put_marker(); put_id(ID_B); put_marker(); put_hb(1, 1);
    play();
    check(n_rep == 1, "R8", "one report while held", 64'(n_rep), 1);
    check(id_value == ID_A, "R8", "held value kept", 64'(id_value), 64'(ID_A));
    check(id_held == 1'b1, "R8", "hold flag set", 64'(id_held), 1);
    @(negedge clk); hold_clear = 1'b1;
    @(negedge clk); hold_clear = 1'b0;
    check(id_held == 1'b0, "R8", "hold released", 64'(id_held), 0);
    put_hb(0, 2); put_marker(); put_id(ID_C); put_marker(); put_hb(1, 1);
    play();
    check(n_rep == 2 && rep_log[1] == ID_C, "R8", "report after release",
          64'(rep_log[1]), 64'(ID_C));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_threshold();
    t_periods();
    t_gaps();
    t_long_runs();
    t_zero_id();
    t_chain();
    t_one_shot();
    finish_run();
  end

endmodule